// File: doc/BRIEF.md
# Serial Gamepad Button Poller

This block reads a twelve-button game controller over a three-wire serial link made of a latch strobe, a shift clock and a returning data line. Once per frame it raises latch so the controller takes a snapshot of its buttons. It then drops latch and gives twelve clock pulses. The bit the controller presents is captured during the low half of each pulse. The controller drives its data line low for a pressed button, so the block inverts each captured bit before storing it.

All waveform timing is counted in microsecond ticks. A clock divider derives these ticks from the system clock, and the number of system clocks per microsecond is a parameter. A frame timer starts a poll every 7000 ticks. The twelve captured bits appear together on the button vector, with a one-cycle strobe that a downstream transmitter uses as its start signal. Between polls, latch rests low and clock rests high.

Top module: `pad_poller`

## Requirements
- R1: While reset is held, latch is low, clock is high, the button vector is all zero and the done strobe is low.
- R2: Every poll begins with latch high for exactly LATCH_HI_US ticks (12), that is LATCH_HI_US*CLK_PER_US system clocks.
- R3: The first falling edge of clock follows the falling edge of latch by exactly LATCH_LO_US ticks (6).
- R4: Each poll gives exactly NUM_BTN (12) clock pulses. Each pulse is low for CLK_LO_US ticks (6) and then high for CLK_HI_US ticks (6).
- R5: The data line is taken once per pulse, in the last system clock of the low phase, after a SYNC_STAGES-deep synchronizer. It must therefore be stable through the final SYNC_STAGES+1 clocks of that low phase.
- R6: Captured data is inverted. A line level of 0 is stored as 1 (pressed) and a level of 1 is stored as 0 (released).
- R7: Bits are stored in arrival order. The bit taken in the first clock pulse lands in buttons_o[0] and the bit from the twelfth pulse lands in buttons_o[11].
- R8: Rising edges of latch in consecutive polls are exactly FRAME_US ticks apart (7000). The first poll starts at the first tick after reset.
- R9: The button vector changes only in the cycle where sample_done_o is high. That strobe lasts one cycle, once per poll, and coincides with the rising clock edge that ends the twelfth low phase.
- R10: Outside a poll, latch is low and clock is high. Latch is never high while clock is low.
- R11: When FRAME_US equals the poll length, the next latch rise follows the twelfth high phase with no idle gap, and the frame period still holds exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| pad_data_i | input | 1 | Serial button data from the controller, low means pressed |
| pad_latch_o | output | 1 | Latch strobe to the controller, high takes the snapshot |
| pad_clk_o | output | 1 | Shift clock to the controller, idles high |
| buttons_o | output | NUM_BTN | Button state, 1 means pressed, bit 0 is the first bit shifted out |
| sample_done_o | output | 1 | One-cycle strobe when a new button vector is valid |

## Verification
Two pairs of events can fall in the same cycle. In the first pair, the sequencer finishes the last high phase of one poll in the same tick that the frame timer asks for the next poll. A second instance, whose frame length equals the poll length, provokes this on every frame. Its latch-to-latch spacing and clock count are then judged exactly. In the second pair, the button pattern changes while a poll is being clocked out. Random changes are applied after latch has fallen, and the vector reported with the done strobe must equal the pattern held when latch was high.

// File: rtl/pad_poller_pkg.sv
// Shared types for the serial gamepad poller.
// Assumes nothing beyond a SystemVerilog 2017 tool flow.
package pad_poller_pkg;

    // Phases of one poll, in the order the sequencer walks them.
    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_LATCH_HI = 3'd1,
        PH_LATCH_LO = 3'd2,
        PH_CLK_LO   = 3'd3,
        PH_CLK_HI   = 3'd4
    } poll_phase_e;

endpackage

// File: rtl/pp_tick_div.sv
// Microsecond tick divider.
// Emits a registered one-cycle pulse every CLK_PER_US system clocks.
// Assumes CLK_PER_US >= 1; with 1 the pulse is high on every cycle after reset.
module pp_tick_div #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);

    generate
        if (CLK_PER_US == 1) begin : g_pass
            // Every cycle is a tick once reset has been released.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) tick_o <= 1'b0;
                else         tick_o <= 1'b1;
            end
        end else begin : g_div
            localparam int CNT_W = $clog2(CLK_PER_US);
            localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_PER_US - 1);

            logic [CNT_W-1:0] cnt_q;

            // Wrap counter over one microsecond of system clocks.
            always_ff @(posedge clk_i) begin
                if (!rst_ni)                cnt_q <= '0;
                else if (cnt_q == CNT_LAST) cnt_q <= '0;
                else                        cnt_q <= cnt_q + 1'b1;
            end

            // Register the wrap as the tick pulse.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) tick_o <= 1'b0;
                else         tick_o <= (cnt_q == CNT_LAST);
            end
        end
    endgenerate

endmodule

// File: rtl/pp_frame_timer.sv
// Frame timer: asks for a new poll once every FRAME_US ticks.
// The counter comes out of reset on its last value, so the first tick
// after reset already requests a poll. start_o is combinational and only
// ever high together with tick_i.
module pp_frame_timer #(
    parameter int FRAME_US = 7000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    output logic start_o
);

    localparam int FR_W = (FRAME_US > 1) ? $clog2(FRAME_US) : 1;
    localparam logic [FR_W-1:0] FR_LAST = FR_W'(FRAME_US - 1);

    logic [FR_W-1:0] fr_cnt_q;

    // Count ticks within the frame; wrap on the last one.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fr_cnt_q <= FR_LAST;
        end else if (tick_i) begin
            if (fr_cnt_q == FR_LAST) fr_cnt_q <= '0;
            else                     fr_cnt_q <= fr_cnt_q + 1'b1;
        end
    end

    // Poll request on the wrapping tick.
    assign start_o = tick_i && (fr_cnt_q == FR_LAST);

endmodule

// File: rtl/pp_sync.sv
// Input synchronizer for the asynchronous controller data line.
// Resets to 1, the released level of the line. STAGES >= 1.
module pp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    generate
        if (STAGES == 1) begin : g_one
            // Single register stage.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) q_o <= 1'b1;
                else         q_o <= d_i;
            end
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;

            // Shift the line through the register chain.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) chain_q <= '1;
                else         chain_q <= {chain_q[STAGES-2:0], d_i};
            end

            assign q_o = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pp_sequencer.sv
// Poll sequencer: walks latch-high, latch-low and NUM_BTN clock low/high
// pairs, each phase lasting a whole number of microsecond ticks.
// Latch and clock are decoded straight from the phase register.
// sample_o marks the final cycle of each low phase, and bit_idx_o names
// the bit being taken. Assumes start_i is only high with tick_i.
module pp_sequencer
    import pad_poller_pkg::*;
#(
    parameter int NUM_BTN     = 12,
    parameter int LATCH_HI_US = 12,
    parameter int LATCH_LO_US = 6,
    parameter int CLK_LO_US   = 6,
    parameter int CLK_HI_US   = 6,
    parameter int BI_W        = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tick_i,
    input  logic            start_i,
    output logic            latch_o,
    output logic            pclk_o,
    output logic            sample_o,
    output logic            last_bit_o,
    output logic [BI_W-1:0] bit_idx_o
);

    localparam int MAX_L = (LATCH_HI_US > LATCH_LO_US) ? LATCH_HI_US : LATCH_LO_US;
    localparam int MAX_C = (CLK_LO_US > CLK_HI_US) ? CLK_LO_US : CLK_HI_US;
    localparam int MAX_D = (MAX_L > MAX_C) ? MAX_L : MAX_C;
    localparam int PH_W  = $clog2(MAX_D + 1);
    localparam logic [BI_W-1:0] LAST_BIT = BI_W'(NUM_BTN - 1);

    poll_phase_e     phase_q, phase_d;
    logic [PH_W-1:0] ph_cnt_q, ph_cnt_d, ph_end;
    logic [BI_W-1:0] bit_q, bit_d;
    logic            ph_done;

    // Last tick count of the current phase.
    always_comb begin
        case (phase_q)
            PH_LATCH_HI: ph_end = PH_W'(LATCH_HI_US - 1);
            PH_LATCH_LO: ph_end = PH_W'(LATCH_LO_US - 1);
            PH_CLK_LO:   ph_end = PH_W'(CLK_LO_US - 1);
            PH_CLK_HI:   ph_end = PH_W'(CLK_HI_US - 1);
            default:     ph_end = '0;
        endcase
    end

    assign ph_done    = tick_i && (phase_q != PH_IDLE) && (ph_cnt_q == ph_end);
    assign last_bit_o = (bit_q == LAST_BIT);

    // Next phase, phase tick counter and bit index.
    always_comb begin
        phase_d  = phase_q;
        ph_cnt_d = ph_cnt_q;
        bit_d    = bit_q;
        if (tick_i && (phase_q != PH_IDLE) && !ph_done) begin
            ph_cnt_d = ph_cnt_q + 1'b1;
        end
        case (phase_q)
            PH_IDLE: begin
                if (start_i) begin
                    phase_d  = PH_LATCH_HI;
                    ph_cnt_d = '0;
                end
            end
            PH_LATCH_HI: begin
                if (ph_done) begin
                    phase_d  = PH_LATCH_LO;
                    ph_cnt_d = '0;
                end
            end
            PH_LATCH_LO: begin
                if (ph_done) begin
                    phase_d  = PH_CLK_LO;
                    ph_cnt_d = '0;
                    bit_d    = '0;
                end
            end
            PH_CLK_LO: begin
                if (ph_done) begin
                    phase_d  = PH_CLK_HI;
                    ph_cnt_d = '0;
                end
            end
            PH_CLK_HI: begin
                if (ph_done) begin
                    ph_cnt_d = '0;
                    if (last_bit_o) begin
                        // A frame request in this very tick starts the next poll at once.
                        phase_d = start_i ? PH_LATCH_HI : PH_IDLE;
                    end else begin
                        phase_d = PH_CLK_LO;
                        bit_d   = bit_q + 1'b1;
                    end
                end
            end
            default: begin
                phase_d  = PH_IDLE;
                ph_cnt_d = '0;
            end
        endcase
    end

    // Phase, counter and bit index registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q  <= PH_IDLE;
            ph_cnt_q <= '0;
            bit_q    <= '0;
        end else begin
            phase_q  <= phase_d;
            ph_cnt_q <= ph_cnt_d;
            bit_q    <= bit_d;
        end
    end

    assign latch_o   = (phase_q == PH_LATCH_HI);
    assign pclk_o    = (phase_q != PH_CLK_LO);
    assign sample_o  = ph_done && (phase_q == PH_CLK_LO);
    assign bit_idx_o = bit_q;

endmodule

// File: rtl/pp_capture.sv
// Button capture: stores each inverted data bit at its arrival index in a
// shadow register. The shadow is copied to the output in one step when the
// last bit arrives, together with a one-cycle done strobe.
// Assumes bit_idx_i stays below NUM_BTN while sample_i is high.
module pp_capture #(
    parameter int NUM_BTN = 12,
    parameter int BI_W    = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sample_i,
    input  logic               last_bit_i,
    input  logic [BI_W-1:0]    bit_idx_i,
    input  logic               line_i,
    output logic [NUM_BTN-1:0] buttons_o,
    output logic               done_o
);

    logic [NUM_BTN-1:0] shadow_q, merged;

    // Shadow with the incoming bit inserted, active-low line inverted.
    always_comb begin
        merged            = shadow_q;
        merged[bit_idx_i] = ~line_i;
    end

    // Shadow register: one bit per sample.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)       shadow_q <= '0;
        else if (sample_i) shadow_q <= merged;
    end

    // Publish the whole vector and strobe done on the last bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            buttons_o <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= sample_i && last_bit_i;
            if (sample_i && last_bit_i) buttons_o <= merged;
        end
    end

endmodule

// File: rtl/pad_poller.sv
// Serial gamepad button poller, top level.
// Ties together the microsecond divider, the frame timer, the data
// synchronizer, the poll sequencer and the capture register.
// Assumes FRAME_US is no shorter than one poll
// (LATCH_HI_US + LATCH_LO_US + NUM_BTN*(CLK_LO_US+CLK_HI_US) ticks).
module pad_poller #(
    parameter int NUM_BTN     = 12,
    parameter int CLK_PER_US  = 50,
    parameter int FRAME_US    = 7000,
    parameter int LATCH_HI_US = 12,
    parameter int LATCH_LO_US = 6,
    parameter int CLK_LO_US   = 6,
    parameter int CLK_HI_US   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               pad_data_i,
    output logic               pad_latch_o,
    output logic               pad_clk_o,
    output logic [NUM_BTN-1:0] buttons_o,
    output logic               sample_done_o
);

    localparam int BI_W = (NUM_BTN > 1) ? $clog2(NUM_BTN) : 1;

    logic            tick;
    logic            frame_start;
    logic            line_sync;
    logic            sample;
    logic            last_bit;
    logic [BI_W-1:0] bit_idx;

    pp_tick_div #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    pp_frame_timer #(.FRAME_US(FRAME_US)) u_frame (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .start_o (frame_start)
    );

    pp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pad_data_i),
        .q_o    (line_sync)
    );

    pp_sequencer #(
        .NUM_BTN     (NUM_BTN),
        .LATCH_HI_US (LATCH_HI_US),
        .LATCH_LO_US (LATCH_LO_US),
        .CLK_LO_US   (CLK_LO_US),
        .CLK_HI_US   (CLK_HI_US),
        .BI_W        (BI_W)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .start_i    (frame_start),
        .latch_o    (pad_latch_o),
        .pclk_o     (pad_clk_o),
        .sample_o   (sample),
        .last_bit_o (last_bit),
        .bit_idx_o  (bit_idx)
    );

    pp_capture #(
        .NUM_BTN (NUM_BTN),
        .BI_W    (BI_W)
    ) u_cap (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sample_i   (sample),
        .last_bit_i (last_bit),
        .bit_idx_i  (bit_idx),
        .line_i     (line_sync),
        .buttons_o  (buttons_o),
        .done_o     (sample_done_o)
    );

endmodule

// File: rtl/pad_poller_chk.sv
// Protocol checker for pad_poller, bound to every instance.
// Watches only the top-level ports. Pulse widths are measured with
// counters, so no long $past windows are needed.
module pad_poller_chk #(
    parameter int NUM_BTN     = 12,
    parameter int CLK_PER_US  = 50,
    parameter int LATCH_HI_US = 12,
    parameter int CLK_LO_US   = 6
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               pad_latch_o,
    input logic               pad_clk_o,
    input logic               sample_done_o,
    input logic [NUM_BTN-1:0] buttons_o
);

    localparam int LATCH_CYC = LATCH_HI_US * CLK_PER_US;
    localparam int LOW_CYC   = CLK_LO_US * CLK_PER_US;

    int hi_run;
    int lo_run;

    // Length of the current latch-high run in system clocks.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)          hi_run <= 0;
        else if (pad_latch_o) hi_run <= hi_run + 1;
        else                  hi_run <= 0;
    end

    // Length of the current clock-low run in system clocks.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        lo_run <= 0;
        else if (!pad_clk_o) lo_run <= lo_run + 1;
        else                lo_run <= 0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (!pad_latch_o && pad_clk_o && !sample_done_o && (buttons_o == '0)));

    assert_latch_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pad_latch_o) |-> (hi_run == LATCH_CYC));

    assert_clk_low_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pad_clk_o) |-> (lo_run == LOW_CYC));

    assert_done_one_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_done_o |=> !sample_done_o);

    assert_done_on_clk_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_done_o |-> $rose(pad_clk_o));

    assert_btn_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sample_done_o |-> $stable(buttons_o));

    assert_latch_clk_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pad_latch_o |-> pad_clk_o);

endmodule

bind pad_poller pad_poller_chk #(
    .NUM_BTN     (NUM_BTN),
    .CLK_PER_US  (CLK_PER_US),
    .LATCH_HI_US (LATCH_HI_US),
    .CLK_LO_US   (CLK_LO_US)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pad_latch_o   (pad_latch_o),
    .pad_clk_o     (pad_clk_o),
    .sample_done_o (sample_done_o),
    .buttons_o     (buttons_o)
);

// File: tb/pad_poller_tb_top.sv
// Controller model plus waveform monitor for one poller instance.
// The model loads the inverted press pattern while latch is high and shifts
// right on each rising clock edge. All observation happens on the falling
// system clock edge.
module pp_pad_monitor #(
    parameter int NB       = 12,
    parameter int CPU      = 2,
    parameter int FRAME_US = 300,
    parameter string TAG   = "a"
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          latch_i,
    input  logic          pclk_i,
    input  logic          done_i,
    input  logic [NB-1:0] buttons_i,
    input  logic [NB-1:0] press_i,
    output logic          data_o,
    output int            n_chk,
    output int            n_err
);

    logic [NB-1:0] pad_shift = '1;
    logic [NB-1:0] snap      = '0;
    logic [NB-1:0] prev_btn  = '0;
    logic prev_latch = 1'b0, prev_clk = 1'b1, prev_done = 1'b0;
    bit   have_rise = 0, in_poll = 0;
    int   cyc = 0, t_lrise = 0, t_lfall = 0, t_cfall = 0, t_crise = 0;
    int   nclk = 0, idle_bad = 0;

    initial begin
        n_chk = 0;
        n_err = 0;
    end

    assign data_o = pad_shift[0];

    // Line levels the controller puts out for a given press pattern.
    function automatic logic [NB-1:0] pad_line_word(input logic [NB-1:0] press);
        return ~press;
    endfunction

    // Button vector expected for a press pattern latched at poll start.
    function automatic logic [NB-1:0] expect_buttons(input logic [NB-1:0] press);
        logic [NB-1:0] line;
        logic [NB-1:0] res;
        line = pad_line_word(press);
        for (int i = 0; i < NB; i++) res[i] = (line[i] == 1'b0);
        return res;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL [%s] %s: actual=%0d expected=%0d (cycle %0d)", TAG, req, act, exp, cyc);
        end
    endtask

    // Controller model and waveform/vector checks.
    always @(negedge clk_i) begin
        cyc = cyc + 1;
        if (!rst_ni) begin
            have_rise  = 0;
            in_poll    = 0;
            nclk       = 0;
            idle_bad   = 0;
            prev_latch = 1'b0;
            prev_clk   = 1'b1;
            prev_done  = 1'b0;
            prev_btn   = buttons_i;
            pad_shift  = '1;
        end else begin
            if (latch_i) begin
                pad_shift = pad_line_word(press_i);
                snap      = press_i;
            end else if (pclk_i && !prev_clk) begin
                pad_shift = {1'b1, pad_shift[NB-1:1]};
            end

            if (latch_i && !prev_latch) begin
                if (have_rise) begin
                    chk(cyc - t_lrise == FRAME_US * CPU, "R8 R11 frame period", cyc - t_lrise, FRAME_US * CPU);
                    chk(nclk == NB, "R4 pulses per poll", nclk, NB);
                    chk(idle_bad == 0, "R10 idle levels", idle_bad, 0);
                end
                have_rise = 1;
                in_poll   = 1;
                t_lrise   = cyc;
                nclk      = 0;
                idle_bad  = 0;
            end
            if (!latch_i && prev_latch) begin
                chk(cyc - t_lrise == 12 * CPU, "R2 latch width", cyc - t_lrise, 12 * CPU);
                t_lfall = cyc;
            end
            if (!pclk_i && prev_clk) begin
                if (nclk == 0) chk(cyc - t_lfall == 6 * CPU, "R3 latch-to-clock gap", cyc - t_lfall, 6 * CPU);
                else           chk(cyc - t_crise == 6 * CPU, "R4 clock high width", cyc - t_crise, 6 * CPU);
                t_cfall = cyc;
            end
            if (pclk_i && !prev_clk) begin
                chk(cyc - t_cfall == 6 * CPU, "R4 clock low width", cyc - t_cfall, 6 * CPU);
                nclk    = nclk + 1;
                t_crise = cyc;
                if (nclk == NB) in_poll = 0;
            end

            if (done_i) begin
                chk(!prev_done && pclk_i && !prev_clk && nclk == NB, "R9 done placement", nclk, NB);
                chk(buttons_i == expect_buttons(snap), "R5 R6 R7 button vector",
                    int'(buttons_i), int'(expect_buttons(snap)));
            end else if (buttons_i != prev_btn) begin
                chk(1'b0, "R9 vector moved without done", int'(buttons_i), int'(prev_btn));
            end
            if (prev_done) chk(!done_i, "R9 done one cycle", int'(done_i), 0);

            if (!in_poll && (latch_i || !pclk_i)) idle_bad = idle_bad + 1;

            prev_latch = latch_i;
            prev_clk   = pclk_i;
            prev_done  = done_i;
            prev_btn   = buttons_i;
        end
    end

endmodule

// Top-level bench: a loose-frame instance and a tight-frame instance
// whose frame equals one poll.
module pad_poller_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NB-1:0] press_a = '0, press_b = '0;
    logic data_a, data_b;
    logic lat_a, pclk_a, done_a, lat_b, pclk_b, done_b;
    logic [NB-1:0] btn_a, btn_b;
    int   ca, ea, cb, eb;
    int   n_chk = 0, n_err = 0;
    bit   finished = 0;
    int unsigned seed_val;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pad_poller #(.NUM_BTN(NB), .CLK_PER_US(2), .FRAME_US(300)) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .pad_data_i (data_a),
        .pad_latch_o (lat_a), .pad_clk_o (pclk_a),
        .buttons_o (btn_a), .sample_done_o (done_a)
    );

    pad_poller #(.NUM_BTN(NB), .CLK_PER_US(1), .FRAME_US(162)) dut_tight (
        .clk_i (clk), .rst_ni (rst_n), .pad_data_i (data_b),
        .pad_latch_o (lat_b), .pad_clk_o (pclk_b),
        .buttons_o (btn_b), .sample_done_o (done_b)
    );

    pp_pad_monitor #(.NB(NB), .CPU(2), .FRAME_US(300), .TAG("loose")) mon_a (
        .clk_i (clk), .rst_ni (rst_n), .latch_i (lat_a), .pclk_i (pclk_a),
        .done_i (done_a), .buttons_i (btn_a), .press_i (press_a),
        .data_o (data_a), .n_chk (ca), .n_err (ea)
    );

    pp_pad_monitor #(.NB(NB), .CPU(1), .FRAME_US(162), .TAG("tight")) mon_b (
        .clk_i (clk), .rst_ni (rst_n), .latch_i (lat_b), .pclk_i (pclk_b),
        .done_i (done_b), .buttons_i (btn_b), .press_i (press_b),
        .data_o (data_b), .n_chk (cb), .n_err (eb)
    );

    task automatic tchk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Directed corner patterns first, then random ones.
    function automatic logic [NB-1:0] next_vec(input int k);
        case (k)
            0:       return 12'hFFF;
            1:       return 12'h001;
            2:       return 12'h800;
            3:       return 12'hA5A;
            4:       return 12'h000;
            default: return NB'($urandom);
        endcase
    endfunction

    // R1 reset levels on both instances.
    task automatic check_reset_levels();
        tchk(!lat_a && !lat_b, "R1 latch low in reset", int'(lat_a) + int'(lat_b), 0);
        tchk(pclk_a && pclk_b, "R1 clock high in reset", int'(pclk_a) + int'(pclk_b), 2);
        tchk(!done_a && !done_b, "R1 done low in reset", int'(done_a) + int'(done_b), 0);
        tchk(btn_a == '0 && btn_b == '0, "R1 buttons clear in reset", int'(btn_a | btn_b), 0);
    endtask

    task automatic finish_run();
        int tot_chk;
        int tot_err;
        tot_chk = n_chk + ca + cb;
        tot_err = n_err + ea + eb;
        $display("Result: errors=%0d of %0d checks", tot_err, tot_chk);
        $finish;
    endtask

    // Main stimulus on the loose instance.
    initial begin
        seed_val = $urandom(32'd7713);
        press_a  = 12'h3C6;
        repeat (4) @(negedge clk);
        check_reset_levels();
        rst_n = 1'b1;
        for (int k = 0; k < 36; k++) begin
            @(posedge done_a);
            @(negedge clk);
            press_a = next_vec(k);
            @(negedge lat_a);
            repeat (7) @(negedge clk);
            // Changes while the poll is clocked out must not reach the vector.
            if (k % 2 == 1) press_a = NB'($urandom);
        end
        // Reset in the middle of a poll.
        @(negedge lat_a);
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_levels();
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(posedge done_a);
            @(negedge clk);
            press_a = NB'($urandom);
        end
        @(posedge done_a);
        repeat (4) @(negedge clk);
        tchk(ca > 200 && cb > 200, "R8 enough polls observed", ca + cb, 400);
        finished = 1;
        finish_run();
    end

    // New random pattern for the tight instance right after each done.
    initial begin
        press_b = 12'h5A3;
        forever begin
            @(posedge done_b);
            @(negedge clk);
            press_b = NB'($urandom);
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk = n_chk + 1;
            n_err = n_err + 1;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

endmodule